// File: doc/BRIEF.md
# VGA Sync Timing Generator

This block produces the raster timing for a 640x480 display driven by a 25 MHz pixel clock. It generates the horizontal and vertical sync pulses and the current beam position. It also raises a flag while that position lies inside the visible picture. Pixel logic placed after it uses the position to fetch or compute a colour, and uses the flag to drive black everywhere outside the picture.

Each axis is a small segment sequencer. It cycles through the visible span, the front porch, the sync pulse and the back porch. On entry to a segment, a down-counter is preloaded with that segment's length minus one. The next segment therefore begins exactly on the boundary. A position counter runs alongside the sequencer and is reported as hcount and vcount. Coordinate 0,0 is the top-left visible pixel. The horizontal axis steps on every enabled clock. The vertical axis steps only on the enabled clock that ends a line.

All segment lengths are parameters. A single parameter bit selects between the two vertical porch sets: front 11 / back 31 lines, or front 10 / back 33 lines.

Top module: `vga_sync_gen`

## Requirements
- R1: A synchronous reset (rst high at a rising edge) sets hcount and vcount to 0, drives hsync and vsync high, and drives active high, which is the top-left visible pixel.
- R2: While en is high, hcount advances by one per clock from 0 to 799 and returns to 0 after 799, giving a line of 800 clocks.
- R3: hsync is active low. It is low exactly while hcount is in 656..751, so each low pulse lasts 96 clocks and the pulse repeats every 800 clocks.
- R4: vcount changes only on the enabled clock where hcount goes from 799 to 0. On that clock it advances by one, and it returns to 0 after the last line of the frame.
- R5: vsync is active low and lasts 2 lines. With porch-select 0 the frame has 524 lines and vsync is low for vcount 491..492. With porch-select 1 the frame has 525 lines and vsync is low for vcount 490..491. Each vsync fall occurs when hcount is 0.
- R6: active is high exactly when hcount < 640 and vcount < 480.
- R7: While en is low, hcount, vcount, hsync and vsync hold their values. When en returns high, counting resumes from the held position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock (25 MHz) |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Count enable; when low, all timing state holds |
| hsync | output | 1 | Horizontal sync, active low |
| vsync | output | 1 | Vertical sync, active low |
| hcount | output | HW (10) | Horizontal position, 0 at the first visible pixel |
| vcount | output | VW (10) | Vertical position, 0 at the first visible line |
| active | output | 1 | High inside the visible 640x480 area |

## Verification
The default instance is run free for three full lines. Every sample of hcount and vcount is compared with the clock count since reset. The timing of the hsync edges separates a correct 96-clock pulse at 656 from an off-by-one segment preload. Two instances with a shortened line, one per porch set, run for more than two frames. Their vsync fall line, low width and frame period tell the two porch sets apart, and also expose a vertical step that is taken on the wrong clock. A held-enable window followed by a single step shows whether every counter and sequencer truly freezes, and a mid-frame reset shows a return to the origin from an arbitrary state.

// File: rtl/vga_timing_pkg.sv
package vga_timing_pkg;

    typedef enum logic [1:0] {
        SEG_DISP  = 2'd0,
        SEG_FP    = 2'd1,
        SEG_PULSE = 2'd2,
        SEG_BP    = 2'd3
    } seg_e;

    // Cyclic order of the segments on one axis
    function automatic seg_e seg_after(seg_e s);
        case (s)
            SEG_DISP:  return SEG_FP;
            SEG_FP:    return SEG_PULSE;
            SEG_PULSE: return SEG_BP;
            default:   return SEG_DISP;
        endcase
    endfunction

endpackage

// File: rtl/vga_axis_seq.sv
module vga_axis_seq
    import vga_timing_pkg::*;
#(
    parameter int  VIS = 640,
    parameter int  FP  = 16,
    parameter int  PW  = 96,
    parameter int  BP  = 48,
    localparam int TOTAL = VIS + FP + PW + BP,
    localparam int CW    = $clog2(TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          step,
    output logic [CW-1:0] pos,
    output logic          sync_n,
    output logic          visible,
    output logic          last
);

    typedef struct packed {
        seg_e          seg;
        logic [CW-1:0] left;
        logic [CW-1:0] pos;
    } axis_t;

    axis_t st_d, st_q;

    // Preload value for a segment: its length minus one
    function automatic logic [CW-1:0] seg_load(seg_e s);
        case (s)
            SEG_DISP:  return CW'(VIS - 1);
            SEG_FP:    return CW'(FP - 1);
            SEG_PULSE: return CW'(PW - 1);
            default:   return CW'(BP - 1);
        endcase
    endfunction

    logic at_end;

    always_comb begin
        st_d   = st_q;
        at_end = (st_q.seg == SEG_BP) && (st_q.left == '0);
        if (step) begin
            st_d.pos = at_end ? '0 : st_q.pos + 1'b1;
            if (st_q.left == '0) begin
                st_d.seg  = seg_after(st_q.seg);
                st_d.left = seg_load(seg_after(st_q.seg));
            end else begin
                st_d.left = st_q.left - 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.seg  <= SEG_DISP;
            st_q.left <= CW'(VIS - 1);
            st_q.pos  <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos     = st_q.pos;
    assign sync_n  = (st_q.seg != SEG_PULSE);
    assign visible = (st_q.seg == SEG_DISP);
    assign last    = at_end;

endmodule

// File: rtl/vga_sync_gen.sv
module vga_sync_gen #(
    parameter int  H_VIS       = 640,
    parameter int  H_FP        = 16,
    parameter int  H_PW        = 96,
    parameter int  H_BP        = 48,
    parameter int  V_VIS       = 480,
    parameter int  V_PW        = 2,
    parameter bit  V_PORCH_SET = 1'b0,
    localparam int V_FP    = V_PORCH_SET ? 10 : 11,
    localparam int V_BP    = V_PORCH_SET ? 33 : 31,
    localparam int H_TOTAL = H_VIS + H_FP + H_PW + H_BP,
    localparam int V_TOTAL = V_VIS + V_FP + V_PW + V_BP,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    output logic          hsync,
    output logic          vsync,
    output logic [HW-1:0] hcount,
    output logic [VW-1:0] vcount,
    output logic          active
);

    logic h_vis, h_last;
    logic v_vis, v_last;
    logic v_step;

    vga_axis_seq #(
        .VIS(H_VIS), .FP(H_FP), .PW(H_PW), .BP(H_BP)
    ) u_h (
        .clk(clk), .rst(rst), .step(en),
        .pos(hcount), .sync_n(hsync), .visible(h_vis), .last(h_last)
    );

    assign v_step = en & h_last;

    vga_axis_seq #(
        .VIS(V_VIS), .FP(V_FP), .PW(V_PW), .BP(V_BP)
    ) u_v (
        .clk(clk), .rst(rst), .step(v_step),
        .pos(vcount), .sync_n(vsync), .visible(v_vis), .last(v_last)
    );

    assign active = h_vis & v_vis;

    // v_last only feeds a neighbour that chains frames; consumed here
    logic frame_end_unused;
    assign frame_end_unused = v_last;

endmodule

// File: rtl/vga_sync_gen_chk.sv
module vga_sync_gen_chk #(
    parameter int  H_VIS       = 640,
    parameter int  H_FP        = 16,
    parameter int  H_PW        = 96,
    parameter int  H_BP        = 48,
    parameter int  V_VIS       = 480,
    parameter int  V_PW        = 2,
    parameter bit  V_PORCH_SET = 1'b0,
    localparam int V_FP    = V_PORCH_SET ? 10 : 11,
    localparam int V_BP    = V_PORCH_SET ? 33 : 31,
    localparam int H_TOTAL = H_VIS + H_FP + H_PW + H_BP,
    localparam int V_TOTAL = V_VIS + V_FP + V_PW + V_BP,
    localparam int HW      = $clog2(H_TOTAL),
    localparam int VW      = $clog2(V_TOTAL)
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic          hsync,
    input logic          vsync,
    input logic [HW-1:0] hcount,
    input logic [VW-1:0] vcount,
    input logic          active
);

    int hc, vc;
    assign hc = int'(hcount);
    assign vc = int'(vcount);

    assert_hcount_step_R2: assert property (@(posedge clk) disable iff (rst)
        (en && hc < H_TOTAL - 1) |=> hc == int'($past(hcount)) + 1);

    assert_hcount_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (en && hc == H_TOTAL - 1) |=> hc == 0);

    assert_hsync_window_R3: assert property (@(posedge clk) disable iff (rst)
        (!hsync) == (hc >= H_VIS + H_FP && hc < H_VIS + H_FP + H_PW));

    assert_vcount_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !(en && hc == H_TOTAL - 1) |=> $stable(vcount));

    assert_vcount_wrap_R4: assert property (@(posedge clk) disable iff (rst)
        (en && hc == H_TOTAL - 1 && vc == V_TOTAL - 1) |=> vc == 0);

    assert_vsync_window_R5: assert property (@(posedge clk) disable iff (rst)
        (!vsync) == (vc >= V_VIS + V_FP && vc < V_VIS + V_FP + V_PW));

    assert_active_match_R6: assert property (@(posedge clk) disable iff (rst)
        active == (hc < H_VIS && vc < V_VIS));

    assert_hold_all_R7: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(hcount) && $stable(vcount) && $stable(hsync) && $stable(vsync)));

endmodule

bind vga_sync_gen vga_sync_gen_chk #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_PW(H_PW), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_PW(V_PW), .V_PORCH_SET(V_PORCH_SET)
) u_chk (
    .clk(clk), .rst(rst), .en(en), .hsync(hsync), .vsync(vsync),
    .hcount(hcount), .vcount(vcount), .active(active)
);

// File: tb/vga_sync_gen_test.sv
module vga_sync_gen_test;

    localparam int CLK_PERIOD = 40;
    localparam int S_LINE     = 82;   // shortened line: 64+4+8+6

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic en  = 1'b1;

    always #(CLK_PERIOD/2) clk = ~clk;

    logic       hs, vs, act;
    logic [9:0] hc, vc;
    logic       hs0, vs0, act0, hs1, vs1, act1;
    logic [6:0] hc0, hc1;
    logic [9:0] vc0, vc1;

    vga_sync_gen uut (
        .clk(clk), .rst(rst), .en(en), .hsync(hs), .vsync(vs),
        .hcount(hc), .vcount(vc), .active(act)
    );

    vga_sync_gen #(.H_VIS(64), .H_FP(4), .H_PW(8), .H_BP(6), .V_PORCH_SET(1'b0)) uut_p0 (
        .clk(clk), .rst(rst), .en(en), .hsync(hs0), .vsync(vs0),
        .hcount(hc0), .vcount(vc0), .active(act0)
    );

    vga_sync_gen #(.H_VIS(64), .H_FP(4), .H_PW(8), .H_BP(6), .V_PORCH_SET(1'b1)) uut_p1 (
        .clk(clk), .rst(rst), .en(en), .hsync(hs1), .vsync(vs1),
        .hcount(hc1), .vcount(vc1), .active(act1)
    );

    int  n_chk  = 0;
    int  n_fail = 0;
    bit  done   = 1'b0;

    task automatic check_eq(input string req, input string what, input longint act_v, input longint exp_v);
        n_chk++;
        if (act_v != exp_v) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // R1: outputs while reset is held
    task automatic test_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        check_eq("R1", "hcount in reset", hc, 0);
        check_eq("R1", "vcount in reset", vc, 0);
        check_eq("R1", "hsync/vsync in reset", {hs, vs}, 2'b11);
        check_eq("R1", "active in reset", act, 1);
    endtask

    // R2 R3 R4 R6: three full lines at default timing
    task automatic test_lines();
        int bad_h = 0, bad_v = 0, bad_a = 0;
        int fall_at = -1, fall_hc = -1, width = -1, period = -1, max_h = 0;
        logic prev_hs = 1'b1;
        rst = 1'b0;
        for (int i = 1; i <= 2400; i++) begin
            @(negedge clk);
            if (hc != 10'(i % 800)) bad_h++;
            if (vc != 10'(i / 800)) bad_v++;
            if (act != (hc < 640 && vc < 480)) bad_a++;
            if (int'(hc) > max_h) max_h = int'(hc);
            if (prev_hs && !hs) begin
                if (fall_at >= 0 && period < 0) period = i - fall_at;
                if (fall_at < 0) begin fall_at = i; fall_hc = int'(hc); end
            end
            if (!prev_hs && hs && width < 0) width = i - fall_at;
            prev_hs = hs;
        end
        check_eq("R2", "hcount mismatches", bad_h, 0);
        check_eq("R2", "largest hcount", max_h, 799);
        check_eq("R3", "hcount at hsync fall", fall_hc, 656);
        check_eq("R3", "hsync low width", width, 96);
        check_eq("R3", "hsync period", period, 800);
        check_eq("R4", "vcount mismatches", bad_v, 0);
        check_eq("R6", "active mismatches", bad_a, 0);
    endtask

    // R7: hold with en low, then one step
    task automatic test_hold();
        int bad = 0;
        logic [9:0] h0, v0;
        logic hs_h, vs_h;
        h0 = hc; v0 = vc; hs_h = hs; vs_h = vs;
        en = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (hc != h0 || vc != v0 || hs != hs_h || vs != vs_h) bad++;
        end
        check_eq("R7", "changes while en low", bad, 0);
        en = 1'b1;
        @(negedge clk);
        check_eq("R7", "hcount after resume", hc, (int'(h0) + 1) % 800);
    endtask

    // R1 R4 R5 R6: mid-frame reset, then two frames on shortened lines
    task automatic test_frames();
        int fall_at[2]  = '{-1, -1};
        int fall_vc[2]  = '{-1, -1};
        int fall_hc[2]  = '{-1, -1};
        int width[2]    = '{-1, -1};
        int period[2]   = '{-1, -1};
        int max_v[2]    = '{0, 0};
        int bad_a       = 0;
        logic prev[2]   = '{1'b1, 1'b1};
        logic cur[2];
        int vcs[2], hcs[2];
        rst = 1'b1;
        repeat (2) @(negedge clk);
        check_eq("R1", "hcount after mid-run reset", hc, 0);
        check_eq("R1", "vcount after mid-run reset", vc0, 0);
        rst = 1'b0;
        for (int i = 1; i <= 86400; i++) begin
            @(negedge clk);
            cur[0] = vs0; cur[1] = vs1;
            vcs[0] = int'(vc0); vcs[1] = int'(vc1);
            hcs[0] = int'(hc0); hcs[1] = int'(hc1);
            if (act0 != (hc0 < 64 && vc0 < 480)) bad_a++;
            if (act1 != (hc1 < 64 && vc1 < 480)) bad_a++;
            for (int k = 0; k < 2; k++) begin
                if (vcs[k] > max_v[k]) max_v[k] = vcs[k];
                if (prev[k] && !cur[k]) begin
                    if (fall_at[k] >= 0 && period[k] < 0) period[k] = i - fall_at[k];
                    if (fall_at[k] < 0) begin
                        fall_at[k] = i; fall_vc[k] = vcs[k]; fall_hc[k] = hcs[k];
                    end
                end
                if (!prev[k] && cur[k] && width[k] < 0) width[k] = i - fall_at[k];
                prev[k] = cur[k];
            end
        end
        check_eq("R5", "set0 vcount at vsync fall", fall_vc[0], 491);
        check_eq("R5", "set1 vcount at vsync fall", fall_vc[1], 490);
        check_eq("R5", "set0 hcount at vsync fall", fall_hc[0], 0);
        check_eq("R5", "set1 hcount at vsync fall", fall_hc[1], 0);
        check_eq("R5", "set0 vsync low clocks", width[0], 2 * S_LINE);
        check_eq("R5", "set1 vsync low clocks", width[1], 2 * S_LINE);
        check_eq("R5", "set0 frame clocks", period[0], 524 * S_LINE);
        check_eq("R5", "set1 frame clocks", period[1], 525 * S_LINE);
        check_eq("R4", "set0 last line", max_v[0], 523);
        check_eq("R4", "set1 last line", max_v[1], 524);
        check_eq("R6", "active mismatches, short lines", bad_a, 0);
    endtask

    initial begin
        en = 1'b1;
        test_reset();
        test_lines();
        test_hold();
        test_frames();
        finish_run();
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule